// File: doc/BRIEF.md
# Serial attenuator frame programmer

This block sits on the host side of a board-level step attenuator that is controlled over a three-wire serial link: a data line, a clock line and a latch strobe. A client hands it an attenuation request in quarter-decibel steps together with a 3-bit device address and pulses `start`. The block builds a 16-bit frame from the request. The low byte is the attenuation step count. The high byte holds the address in its three low bits, and its remaining bits are driven as zero. The frame is shifted out least significant bit first, with data changing while the serial clock is low. The block then strobes the latch line to commit the frame.

Every interval on the wire comes from nanosecond parameters and the system clock frequency. The intervals are the clock high and low phases, the latch setup after the last clock rise, the latch pulse width and the minimum spacing between two commits. Each is rounded up to whole system cycles. A request larger than the step limit is refused with a one-cycle error pulse and produces no activity on the wire. The block reports `busy` while it owns the link and pulses `done` once the latch strobe has fallen.

Top module: `atten_frame_prog`

## Requirements
- R1: Each accepted update produces exactly 16 rising edges of `ser_clk`. The `ser_data` values seen at those edges are, in order, `atten_q` bits 0 to 7, then `dev_addr` bits 0 to 2, then five zeros. For example, 73 steps at address 3 gives the frame value 16'h0349 when read with the last bit as the MSB.
- R2: `ser_clk` and `ser_latch` are low whenever `busy` is low. Every high phase of `ser_clk` lasts exactly HALF cycles, and every low phase lasts at least HALF cycles. HALF is ceil(SCLK_HALF_NS * SYS_CLK_HZ / 1e9).
- R3: `ser_data` holds its value for as long as `ser_clk` stays high. It changes only at the edge where `ser_clk` falls, or while `ser_clk` is low.
- R4: `ser_latch` is low at every rising edge of `ser_clk`. It rises no sooner than ceil(LE_SETUP_NS * SYS_CLK_HZ / 1e9) cycles after the last rising edge.
- R5: `ser_latch` stays high for exactly ceil(LE_PULSE_NS * SYS_CLK_HZ / 1e9) cycles.
- R6: Two successive rising edges of `ser_latch` are at least ceil(UPDATE_GAP_NS * SYS_CLK_HZ / 1e9) cycles apart. The first commit after reset is not delayed by this spacing.
- R7: `done` is high for exactly one cycle, in the cycle after `ser_latch` has returned low, and `busy` is low in that cycle.
- R8: A `start` with `atten_q` greater than MAX_STEP (127) is refused. `err` is high for one cycle, in the cycle after the request. No clock edge and no latch strobe follow, and `busy` stays low.
- R9: A `start` while `busy` is high is ignored. The update in flight completes with its original frame, and no further update follows.
- R10: After reset, `busy`, `done`, `err`, `ser_data`, `ser_clk` and `ser_latch` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| atten_q | input | WORD_W (8) | Requested attenuation in quarter-dB steps |
| dev_addr | input | ADDR_W (3) | Target device address |
| busy | output | 1 | High while an update owns the serial link |
| done | output | 1 | One-cycle pulse after the latch strobe ends |
| err | output | 1 | One-cycle pulse for an out-of-range request |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line, idles low |
| ser_latch | output | 1 | Latch strobe line |

## Verification
The bench sweeps every legal step count from 0 to 127, each with a different address. This catches a frame that is reversed, off by one bit or missing a byte, because the captured word would not match the expected value. Requests sent back to back test the commit spacing: a design that only times from `start`, or that ignores the spacing, raises the second latch strobe too early. The first commit after reset is timed to catch the opposite fault, a spacing timer that powers up unexpired. Out-of-range values at 128, 200 and 255 and a second `start` during a transfer show whether a design starts a transaction it should refuse or restarts partway through.

// File: rtl/afp_pkg.sv
package afp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_SETUP,
      ST_PULSE,
      ST_FIN
   } afp_state_e;

   // nanoseconds to system cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(input int unsigned hz, input int unsigned ns);
      longint unsigned prod;
      longint unsigned cyc;
      prod = longint'(ns) * longint'(hz);
      cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
      if (cyc < 64'd1) cyc = 64'd1;
      return int'(cyc);
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/afp_downcnt.sv
module afp_downcnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("afp_downcnt: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/afp_frame_shift.sv
module afp_frame_shift #(
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic               shift,
   output logic               bit_out
);

   logic [FRAME_W-1:0] sh_q;

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("afp_frame_shift: FRAME_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      sh_q <= '0;
      else if (load)   sh_q <= frame;
      else if (shift)  sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
   end

   assign bit_out = sh_q[0];

endmodule

// File: rtl/atten_frame_prog.sv
module atten_frame_prog #(
   parameter int unsigned SYS_CLK_HZ    = 250_000_000,
   parameter int unsigned WORD_W        = 8,
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned MAX_STEP      = 127,
   parameter int unsigned SCLK_HALF_NS  = 50,
   parameter int unsigned LE_SETUP_NS   = 10,
   parameter int unsigned LE_PULSE_NS   = 30,
   parameter int unsigned UPDATE_GAP_NS = 40_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] atten_q,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              ser_data,
   output logic              ser_clk,
   output logic              ser_latch
);
   import afp_pkg::*;

   localparam int unsigned FRAME_W   = 2 * WORD_W;
   localparam int unsigned BIT_W     = $clog2(FRAME_W);
   localparam int unsigned HALF_CYC  = ns_to_cyc(SYS_CLK_HZ, SCLK_HALF_NS);
   localparam int unsigned SETUP_CYC = ns_to_cyc(SYS_CLK_HZ, LE_SETUP_NS);
   localparam int unsigned PULSE_CYC = ns_to_cyc(SYS_CLK_HZ, LE_PULSE_NS);
   localparam int unsigned GAP_CYC   = ns_to_cyc(SYS_CLK_HZ, UPDATE_GAP_NS);
   localparam int unsigned PH_MAX    = max3(HALF_CYC, SETUP_CYC, PULSE_CYC);
   localparam int unsigned PH_W      = $clog2(PH_MAX + 1);
   localparam int unsigned GAP_W     = $clog2(GAP_CYC + 1);

   localparam logic [PH_W-1:0]   HALF_V  = PH_W'(HALF_CYC - 1);
   localparam logic [PH_W-1:0]   SETUP_V = PH_W'(SETUP_CYC - 1);
   localparam logic [PH_W-1:0]   PULSE_V = PH_W'(PULSE_CYC - 1);
   localparam logic [GAP_W-1:0]  GAP_V   = GAP_W'(GAP_CYC - 1);
   localparam logic [WORD_W-1:0] LIMIT   = WORD_W'(MAX_STEP);
   localparam logic [BIT_W-1:0]  LAST_B  = BIT_W'(FRAME_W - 1);

   generate
      if (ADDR_W > WORD_W) begin : g_bad_addr
         $error("atten_frame_prog: ADDR_W exceeds WORD_W");
      end
      if (MAX_STEP >= (1 << WORD_W)) begin : g_bad_step
         $error("atten_frame_prog: MAX_STEP does not fit in WORD_W");
      end
   endgenerate

   // frame layout: address word above attenuation word
   logic [FRAME_W-1:0] frame_w;
   generate
      if (ADDR_W < WORD_W) begin : g_pad
         assign frame_w = {{(WORD_W - ADDR_W){1'b0}}, dev_addr, atten_q};
      end else begin : g_nopad
         assign frame_w = {dev_addr, atten_q};
      end
   endgenerate

   afp_state_e        state_q, state_d;
   logic              ph_load, ph_zero;
   logic [PH_W-1:0]   ph_val;
   logic              gap_load, gap_zero;
   logic              fr_load, fr_shift;
   logic [BIT_W-1:0]  bit_q;
   logic              sclk_q, latch_q, done_q, err_q;
   logic              idle, in_range, accept, last_bit;

   assign idle     = (state_q == ST_IDLE);
   assign in_range = (atten_q <= LIMIT);
   assign accept   = idle && start && in_range;
   assign last_bit = (bit_q == LAST_B);

   afp_downcnt #(.W(PH_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ph_load),
      .val   (ph_val),
      .zero  (ph_zero)
   );

   afp_downcnt #(.W(GAP_W)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (gap_load),
      .val   (GAP_V),
      .zero  (gap_zero)
   );

   afp_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fr_load),
      .frame   (frame_w),
      .shift   (fr_shift),
      .bit_out (ser_data)
   );

   always_comb begin
      state_d  = state_q;
      ph_load  = 1'b0;
      ph_val   = '0;
      gap_load = 1'b0;
      fr_load  = 1'b0;
      fr_shift = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (accept) begin
               state_d = ST_LOW;
               ph_load = 1'b1;
               ph_val  = HALF_V;
               fr_load = 1'b1;
            end
         end
         ST_LOW: begin
            if (ph_zero) begin
               state_d = ST_HIGH;
               ph_load = 1'b1;
               ph_val  = HALF_V;
            end
         end
         ST_HIGH: begin
            if (ph_zero) begin
               fr_shift = 1'b1;
               ph_load  = 1'b1;
               if (last_bit) begin
                  state_d = ST_SETUP;
                  ph_val  = SETUP_V;
               end else begin
                  state_d = ST_LOW;
                  ph_val  = HALF_V;
               end
            end
         end
         ST_SETUP: begin
            if (ph_zero && gap_zero) begin
               state_d  = ST_PULSE;
               ph_load  = 1'b1;
               ph_val   = PULSE_V;
               gap_load = 1'b1;
            end
         end
         ST_PULSE: begin
            if (ph_zero) state_d = ST_FIN;
         end
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         sclk_q  <= 1'b0;
         latch_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (fr_load)       bit_q <= '0;
         else if (fr_shift) bit_q <= bit_q + 1'b1;
         sclk_q  <= (state_d == ST_HIGH);
         latch_q <= (state_d == ST_PULSE);
         done_q  <= (state_q == ST_FIN);
         err_q   <= idle && start && !in_range;
      end
   end

   assign busy      = !idle;
   assign done      = done_q;
   assign err       = err_q;
   assign ser_clk   = sclk_q;
   assign ser_latch = latch_q;

endmodule

// File: rtl/afp_checker.sv
module afp_checker #(
   parameter int unsigned HALF_CYC  = 1,
   parameter int unsigned PULSE_CYC = 1,
   parameter int unsigned GAP_CYC   = 1
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic err,
   input logic ser_data,
   input logic ser_clk,
   input logic ser_latch
);

   int unsigned hi_run, lat_run, since;
   logic        lat_d, seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run  <= 0;
         lat_run <= 0;
         since   <= 0;
         lat_d   <= 1'b0;
         seen    <= 1'b0;
      end else begin
         hi_run  <= ser_clk   ? hi_run + 1  : 0;
         lat_run <= ser_latch ? lat_run + 1 : 0;
         lat_d   <= ser_latch;
         seen    <= seen | ser_latch;
         if (ser_latch && !lat_d)  since <= 1;
         else if (since < GAP_CYC) since <= since + 1;
      end
   end

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_latch));

   // R2
   clk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> (hi_run == HALF_CYC));

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   // R4
   latch_vs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_latch |-> !ser_clk);

   // R5
   latch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_latch) |-> (lat_run == PULSE_CYC));

   // R6
   update_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ser_latch) && seen) |-> (since >= GAP_CYC));

   // R7
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_latch) |=> (done && !busy));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !ser_clk && !ser_latch));

endmodule

bind atten_frame_prog afp_checker #(
   .HALF_CYC  (HALF_CYC),
   .PULSE_CYC (PULSE_CYC),
   .GAP_CYC   (GAP_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .ser_data  (ser_data),
   .ser_clk   (ser_clk),
   .ser_latch (ser_latch)
);

// File: tb/atten_frame_prog_test.sv
`timescale 1ns/1ps
module atten_frame_prog_test;

   localparam int CLK_MHZ = 250;
   localparam int HALF_NS = 8;
   localparam int SET_NS  = 8;
   localparam int PW_NS   = 12;
   localparam int GAP_NS  = 400;
   localparam int E_HALF  = (HALF_NS * CLK_MHZ + 999) / 1000;
   localparam int E_SET   = (SET_NS * CLK_MHZ + 999) / 1000;
   localparam int E_PW    = (PW_NS * CLK_MHZ + 999) / 1000;
   localparam int E_GAP   = (GAP_NS * CLK_MHZ + 999) / 1000;
   localparam int FIRST_MAX = 32 * E_HALF + E_SET + 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] atten_q = '0;
   logic [2:0] dev_addr = '0;
   logic       busy, done, err, ser_data, ser_clk, ser_latch;

   atten_frame_prog #(
      .SYS_CLK_HZ    (CLK_MHZ * 1_000_000),
      .SCLK_HALF_NS  (HALF_NS),
      .LE_SETUP_NS   (SET_NS),
      .LE_PULSE_NS   (PW_NS),
      .UPDATE_GAP_NS (GAP_NS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .atten_q(atten_q), .dev_addr(dev_addr),
      .busy(busy), .done(done), .err(err), .ser_data(ser_data), .ser_clk(ser_clk),
      .ser_latch(ser_latch)
   );

   always #2 clk = ~clk;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor state
   logic [15:0] exp_frame = '0;
   logic [15:0] cap = '0;
   int  rises = 0, total_rises = 0, n_latch = 0;
   int  hi_run = 0, lo_run = 1000, lat_hi = 0;
   int  last_rise = 0, prev_lat = 0, start_cyc = 0;
   bit  have_prev = 0, done_due = 0, hold_bad = 0, bad_mode = 0, mon_on = 0;
   logic p_clk = 0, p_lat = 0, p_data = 0;

   always @(negedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog (all requirements): actual %0d expected < 100000", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
      if (mon_on) begin
         if (done_due) begin
            chk(done && !busy, "R7 done one cycle after latch falls, busy low", {done, busy}, 2'b10);
            done_due = 0;
         end else if (done) begin
            chk(0, "R7 spurious done", 1, 0);
         end
         if (err && !bad_mode) chk(0, "R8 spurious err", 1, 0);
         if (!busy && (ser_clk || ser_latch)) chk(0, "R2 wire active while idle", {ser_clk, ser_latch}, 0);
         if (ser_clk && p_clk && ser_data != p_data) hold_bad = 1;
         if (ser_clk && !p_clk) begin
            chk(!ser_latch, "R4 latch low at clock rise", ser_latch, 0);
            chk(lo_run >= E_HALF, "R2 low phase length", lo_run, E_HALF);
            if (rises < 16) cap[rises] = ser_data;
            rises++;
            total_rises++;
            last_rise = cyc;
         end
         if (!ser_clk && p_clk) begin
            chk(hi_run == E_HALF, "R2 high phase length", hi_run, E_HALF);
            chk(!hold_bad, "R3 data stable while clock high", hold_bad, 0);
            hold_bad = 0;
         end
         if (ser_latch && !p_lat) begin
            chk(rises == 16, "R1 clock edge count", rises, 16);
            chk(cap == exp_frame, "R1 frame content", cap, exp_frame);
            chk(cyc - last_rise >= E_SET, "R4 latch setup", cyc - last_rise, E_SET);
            if (have_prev)
               chk(cyc - prev_lat >= E_GAP, "R6 update spacing", cyc - prev_lat, E_GAP);
            else
               chk(cyc - start_cyc <= FIRST_MAX, "R6 first update not delayed",
                   cyc - start_cyc, FIRST_MAX);
            prev_lat = cyc;
            have_prev = 1;
         end
         if (!ser_latch && p_lat) begin
            chk(lat_hi == E_PW, "R5 latch width", lat_hi, E_PW);
            rises = 0;
            n_latch++;
            done_due = 1;
         end
         if (ser_clk) begin hi_run = p_clk ? hi_run + 1 : 1; end
         else begin lo_run = p_clk ? 1 : lo_run + 1; end
         lat_hi = ser_latch ? (p_lat ? lat_hi + 1 : 1) : 0;
      end
      p_clk = ser_clk;
      p_lat = ser_latch;
      p_data = ser_data;
   end

   task automatic send(input int a, input int ad);
      while (busy) @(negedge clk);
      exp_frame = {5'b0, 3'(ad), 8'(a)};
      start_cyc = cyc;
      atten_q = 8'(a);
      dev_addr = 3'(ad);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
   endtask

   task automatic send_bad(input int a);
      int r0;
      while (busy) @(negedge clk);
      r0 = total_rises;
      bad_mode = 1;
      atten_q = 8'(a);
      dev_addr = 3'd7;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err && !busy, "R8 err pulse on out-of-range request", {err, busy}, 2'b10);
      @(negedge clk);
      chk(!err, "R8 err lasts one cycle", err, 0);
      bad_mode = 0;
      repeat (40) begin
         @(negedge clk);
         if (busy) chk(0, "R8 busy after refused request", 1, 0);
      end
      chk(total_rises == r0, "R8 no clock edges after refusal", total_rises - r0, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk({busy, done, err, ser_data, ser_clk, ser_latch} == 6'b0, "R10 reset outputs",
          {busy, done, err, ser_data, ser_clk, ser_latch}, 0);
      mon_on = 1;

      // R1 worked example: 73 steps at address 3
      send(73, 3);
      chk(exp_frame == 16'h0349, "R1 example frame value", exp_frame, 16'h0349);

      // R1 R2 R3 sweep over every legal step count
      for (int a = 0; a < 128; a++) send(a, (a * 5 + 3) % 8);

      // R8 out-of-range requests
      send_bad(128);
      send_bad(200);
      send_bad(255);

      // R9 start while busy is ignored
      begin
         int n0;
         while (busy) @(negedge clk);
         n0 = n_latch;
         exp_frame = {5'b0, 3'd6, 8'd100};
         start_cyc = cyc;
         atten_q = 8'd100;
         dev_addr = 3'd6;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (10) @(negedge clk);
         atten_q = 8'd5;
         dev_addr = 3'd1;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         while (!done) @(negedge clk);
         repeat (E_GAP + 150) @(negedge clk);
         chk(n_latch == n0 + 1, "R9 one update despite extra start", n_latch - n0, 1);
         chk(!busy, "R9 idle afterwards", busy, 0);
      end

      // R6 back-to-back requests after idle
      send(127, 0);
      send(0, 7);

      repeat (5) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule